// File: doc/BRIEF.md
# SIMD Rounding Shift-Right-Accumulate Unit

This block is a one-cycle registered datapath for packed unsigned integers. It takes a 128-bit source vector, a 128-bit accumulator vector and a 7-bit shift immediate. From that one immediate it works out both the lane width (8, 16, 32 or 64 bits) and the right-shift distance. Each source lane can receive a rounding bias. The lane is then shifted right, and the shifted value is added, with wraparound, to the matching accumulator lane.

Two mode bits select a truncating variant (no bias) and a non-accumulating variant (the accumulator is read as zero). A scalar/vector select and a width bit choose the data span:

- a single 64-bit element,
- a 64-bit vector, or
- a 128-bit vector.

The unit raises a flag for immediate and mode combinations that have no meaning. For those combinations the result is forced to zero. Results and the flag appear one clock after the input strobe.

Top module: `simd_rsra_unit`

## Requirements
- R1: The lane width comes from the top four immediate bits `imm7[6:3]`. The highest set bit at position k of that nibble gives a width of 8·2^k. So bit 3 gives 64, bit 2 gives 32, bit 1 gives 16 and bit 0 gives 8. In scalar mode the width is always 64.
- R2: The shift distance is 2·width minus the unsigned value of `imm7`. It runs from 1 (imm7 = 2·width−1) up to the full width (imm7 = width).
- R3: With `round_en`=1, each lane gets the bias 2^(shift−1) added before the shift. With `round_en`=0 no bias is added, so the result is truncated.
- R4: The bias is added at one bit more than the lane width, so a carry out of the lane survives the shift. With 8-bit lanes, shift 8 and rounding on, an all-ones lane gives 1.
- R5: The shifted value is added to the accumulator lane modulo 2^width. There is no saturation and no carry between lanes.
- R6: With `accum_en`=0 the accumulator input has no effect, and each lane result equals the shifted value alone.
- R7: In vector mode with `wide_q`=0, only the low 64 bits are processed and `result[127:64]` is zero. With `wide_q`=1 all 128 bits are processed. The lane count is the span divided by the width.
- R8: `undef_flag` is 1 and `result` is all zeros in each of these cases:
  - vector mode with `imm7[6:3]`=0000;
  - vector mode with `imm7[6]`=1 and `wide_q`=0;
  - scalar mode with `imm7[6]`=0.
- R9: Scalar mode (`scalar_mode`=1) handles one 64-bit lane in bits [63:0]. It ignores `wide_q` and drives `result[127:64]` to zero.
- R10: Reset clears `out_valid`, `result` and `undef_flag`. The outputs for an input sampled with `in_valid`=1 appear after that clock edge, with `out_valid`=1. A cycle with `in_valid`=0 yields `out_valid`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| src_vec | input | 128 | Source lanes |
| acc_vec | input | 128 | Accumulator lanes |
| wide_q | input | 1 | Vector span: 0 = 64 bits, 1 = 128 bits |
| scalar_mode | input | 1 | 1 = single 64-bit element |
| imm7 | input | 7 | Shift immediate carrying width and distance |
| round_en | input | 1 | 1 = add rounding bias |
| accum_en | input | 1 | 1 = add accumulator lane |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Lane results |
| undef_flag | output | 1 | Unsupported encoding |

## Verification
The bench drives all four lane widths at the shortest and longest shift, with all-ones sources and rounding on. A design that drops the carry bit returns 0 instead of 1 for those lanes, and one that mis-decodes the width splits lanes in the wrong places. Accumulators full of ones expose a design that saturates or lets carries cross into the next lane. The narrow-span and scalar cases catch leftover upper-half data. Each of the three unsupported encodings is applied, which catches a missing flag or a non-zero result.

// File: rtl/rsra_pkg.sv
package rsra_pkg;

    localparam int VEC_W   = 128;
    localparam int HALF_W  = VEC_W / 2;
    localparam int IMM_W   = 7;
    localparam int SHIFT_W = 7;
    localparam int NUM_WIDTHS = 4;

    typedef enum logic [1:0] {
        LW8  = 2'd0,
        LW16 = 2'd1,
        LW32 = 2'd2,
        LW64 = 2'd3
    } lane_w_e;

    typedef struct packed {
        lane_w_e              width;
        logic [SHIFT_W-1:0]   shift;
        logic                 half;
        logic                 undef;
    } rsra_ctrl_t;

    typedef struct packed {
        logic round_en;
        logic accum_en;
    } rsra_mode_t;

    // Priority pick of the lane width from the high nibble of the immediate.
    function automatic lane_w_e width_from_nibble(input logic [3:0] nib);
        if (nib[3])      return LW64;
        else if (nib[2]) return LW32;
        else if (nib[1]) return LW16;
        else             return LW8;
    endfunction

    // Twice the lane width, used as the base of the shift computation.
    function automatic logic [7:0] twice_width(input lane_w_e w);
        case (w)
            LW8:     return 8'd16;
            LW16:    return 8'd32;
            LW32:    return 8'd64;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/rsra_decode.sv
module rsra_decode
    import rsra_pkg::*;
(
    input  logic [IMM_W-1:0] imm7,
    input  logic             wide_q,
    input  logic             scalar_mode,
    output rsra_ctrl_t       ctrl
);
    logic [3:0] nib;
    logic [7:0] shift_full;
    lane_w_e    width;

    assign nib = imm7[6:3];

    always_comb begin
        if (scalar_mode) begin
            width      = LW64;
            ctrl.undef = ~nib[3];
            ctrl.half  = 1'b1;
        end else begin
            width      = width_from_nibble(nib);
            ctrl.undef = (nib == 4'b0000) | (nib[3] & ~wide_q);
            ctrl.half  = ~wide_q;
        end
        shift_full = twice_width(width) - {1'b0, imm7};
        ctrl.width = width;
        ctrl.shift = shift_full[SHIFT_W-1:0];
    end

endmodule

// File: rtl/rsra_lane.sv
module rsra_lane
    import rsra_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0]  elem,
    input  logic [LANE_W-1:0]  acc,
    input  logic [SHIFT_W-1:0] shift,
    input  rsra_mode_t         mode,
    output logic [LANE_W-1:0]  res
);
    localparam int EXT_W = LANE_W + 1;

    logic [EXT_W-1:0]  bias;
    logic [EXT_W-1:0]  biased;
    logic [EXT_W-1:0]  shifted;
    logic [LANE_W-1:0] acc_eff;

    always_comb begin
        bias    = mode.round_en ? (EXT_W'(1) << (shift - SHIFT_W'(1))) : '0;
        biased  = {1'b0, elem} + bias;
        shifted = biased >> shift;
        acc_eff = mode.accum_en ? acc : '0;
        res     = acc_eff + shifted[LANE_W-1:0];
    end

endmodule

// File: rtl/rsra_lane_array.sv
module rsra_lane_array
    import rsra_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int SPAN_W = VEC_W
) (
    input  logic [SPAN_W-1:0]  src,
    input  logic [SPAN_W-1:0]  acc,
    input  logic [SHIFT_W-1:0] shift,
    input  rsra_mode_t         mode,
    output logic [SPAN_W-1:0]  res
);
    localparam int LANES = SPAN_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rsra_lane #(.LANE_W(LANE_W)) u_lane (
            .elem  (src[i*LANE_W +: LANE_W]),
            .acc   (acc[i*LANE_W +: LANE_W]),
            .shift (shift),
            .mode  (mode),
            .res   (res[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_rsra_unit.sv
module simd_rsra_unit
    import rsra_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [127:0]     src_vec,
    input  logic [127:0]     acc_vec,
    input  logic             wide_q,
    input  logic             scalar_mode,
    input  logic [6:0]       imm7,
    input  logic             round_en,
    input  logic             accum_en,
    output logic             out_valid,
    output logic [127:0]     result,
    output logic             undef_flag
);
    rsra_ctrl_t ctrl;
    rsra_mode_t mode;
    logic [VEC_W-1:0] per_width [NUM_WIDTHS];
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] next_res;

    assign mode.round_en = round_en;
    assign mode.accum_en = accum_en;

    rsra_decode u_dec (
        .imm7        (imm7),
        .wide_q      (wide_q),
        .scalar_mode (scalar_mode),
        .ctrl        (ctrl)
    );

    // One lane array per supported width; the decoded width picks one.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int LW = 8 << g;
        rsra_lane_array #(.LANE_W(LW), .SPAN_W(VEC_W)) u_arr (
            .src   (src_vec),
            .acc   (acc_vec),
            .shift (ctrl.shift),
            .mode  (mode),
            .res   (per_width[g])
        );
    end

    always_comb begin
        picked = per_width[ctrl.width];
        if (ctrl.undef) begin
            next_res = '0;
        end else if (ctrl.half) begin
            next_res = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        end else begin
            next_res = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            undef_flag <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            result     <= next_res;
            undef_flag <= ctrl.undef;
        end
    end

endmodule

// File: rtl/rsra_checker.sv
module rsra_checker (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] src_vec,
    input logic         wide_q,
    input logic         scalar_mode,
    input logic [6:0]   imm7,
    input logic         round_en,
    input logic         accum_en,
    input logic         out_valid,
    input logic [127:0] result,
    input logic         undef_flag
);
    logic         pv_q, pv_scalar, pv_round, pv_accum;
    logic [6:0]   pv_imm;
    logic [127:0] pv_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q <= 1'b1; pv_scalar <= 1'b0; pv_round <= 1'b0;
            pv_accum <= 1'b0; pv_imm <= 7'd8; pv_src <= '0;
        end else begin
            pv_q <= wide_q; pv_scalar <= scalar_mode; pv_round <= round_en;
            pv_accum <= accum_en; pv_imm <= imm7; pv_src <= src_vec;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        undef_flag |-> (result == '0)); // R8

    AST_UNDEF_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pv_scalar && pv_imm[6:3] == 4'b0000) |-> undef_flag); // R8

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (pv_scalar || !pv_q)) |-> (result[127:64] == '0)); // R7

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pv_src == '0 && !pv_round && !pv_accum) |-> (result == '0)); // R6

endmodule

bind simd_rsra_unit rsra_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .wide_q(wide_q), .scalar_mode(scalar_mode), .imm7(imm7),
    .round_en(round_en), .accum_en(accum_en), .out_valid(out_valid),
    .result(result), .undef_flag(undef_flag)
);

// File: tb/simd_rsra_unit_bench.sv
module simd_rsra_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0;
    logic [127:0] acc_vec = '0;
    logic         wide_q = 1'b0;
    logic         scalar_mode = 1'b0;
    logic [6:0]   imm7 = '0;
    logic         round_en = 1'b0;
    logic         accum_en = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         undef_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [127:0] res;
        logic         und;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_rsra_unit u_simd_rsra_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .acc_vec(acc_vec), .wide_q(wide_q), .scalar_mode(scalar_mode),
        .imm7(imm7), .round_en(round_en), .accum_en(accum_en),
        .out_valid(out_valid), .result(result), .undef_flag(undef_flag)
    );

    // Behavioural reference written from the requirements.
    function automatic logic [128:0] ref_calc(input logic [127:0] s, a,
            input logic q, sc, input logic [6:0] im, input logic rn, ac);
        logic [3:0]   h;
        logic         und;
        int           w, sh, span;
        logic [127:0] r;
        logic [64:0]  e, av, rc, t;
        h = im[6:3];
        r = '0;
        if (sc) begin
            w = 64; und = !h[3]; span = 64;
        end else begin
            und  = (h == 4'b0000) || (h[3] && !q);
            w    = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
            span = q ? 128 : 64;
        end
        if (und) return {1'b1, 128'b0};
        sh = 2 * w - int'(im);
        for (int l = 0; l < span / w; l++) begin
            e = '0; av = '0;
            for (int b = 0; b < w; b++) begin
                e[b]  = s[l*w + b];
                av[b] = ac ? a[l*w + b] : 1'b0;
            end
            rc = rn ? (65'd1 << (sh - 1)) : 65'd0;
            t  = (e + rc) >> sh;
            t  = av + t;
            for (int b = 0; b < w; b++) r[l*w + b] = t[b];
        end
        return {1'b0, r};
    endfunction

    task automatic apply(input logic [127:0] s, a, input logic q, sc,
            input logic [6:0] im, input logic rn, ac);
        @(negedge clk);
        src_vec = s; acc_vec = a; wide_q = q; scalar_mode = sc;
        imm7 = im; round_en = rn; accum_en = ac; in_valid = 1'b1;
    endtask

    task automatic send_model(input logic [127:0] s, a, input logic q, sc,
            input logic [6:0] im, input logic rn, ac, input string tag);
        exp_t x;
        logic [128:0] m;
        m = ref_calc(s, a, q, sc, im, rn, ac);
        x.res = m[127:0]; x.und = m[128]; x.tag = tag;
        apply(s, a, q, sc, im, rn, ac);
        sb.push_back(x);
    endtask

    task automatic send_hand(input logic [127:0] s, a, input logic q, sc,
            input logic [6:0] im, input logic rn, ac,
            input logic [127:0] er, input logic eu, input string tag);
        exp_t x;
        x.res = er; x.und = eu; x.tag = tag;
        apply(s, a, q, sc, im, rn, ac);
        sb.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops one expected item for every output strobe.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t x;
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
            end else begin
                x = sb.pop_front();
                if (result !== x.res || undef_flag !== x.und) begin
                    n_fail++;
                    $display("FAIL %s: actual res=%h und=%b expected res=%h und=%b",
                             x.tag, result, undef_flag, x.res, x.und);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG_CYCLES) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG_CYCLES);
                finish_run();
            end
        end
    end

    initial begin
        logic [127:0] ones;
        logic [127:0] alt;
        ones = '1;
        alt  = {8{16'hA5C3}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0 || undef_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: actual v=%b res=%h u=%b expected 0/0/0",
                     out_valid, result, undef_flag);
        end
        rst = 1'b0;

        // R4 carry kept: 8-bit lanes, shift 8, rounding
        send_hand(ones, '0, 1, 0, 7'd8, 1, 1, {16{8'h01}}, 0, "R4 carry");
        // R3 truncation drops the bias
        send_hand(ones, '0, 1, 0, 7'd8, 0, 1, '0, 0, "R3 truncate");
        // R3 rounding at shift 1 on 16-bit lanes: 3+1 >> 1 = 2
        send_hand({8{16'h0003}}, '0, 1, 0, 7'd31, 1, 0, {8{16'h0002}}, 0, "R3 round up");
        // R5 wrap per lane, no carry across lanes
        send_hand({8{16'h0002}}, ones, 1, 0, 7'd31, 0, 1, '0, 0, "R5 wrap");
        // R6 accumulator ignored
        send_hand({16{8'h10}}, ones, 1, 0, 7'd15, 0, 0, {16{8'h08}}, 0, "R6 no accum");
        // R7 narrow span, 32-bit lanes, shift 1
        send_hand(ones, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 0, 0, 7'd63, 0, 1,
                  {64'h0, 64'h7FFF_FFFF_7FFF_FFFF}, 0, "R7 narrow");
        // R8 undefined encodings
        send_hand(ones, ones, 1, 0, 7'd0, 1, 1, '0, 1, "R8 nibble zero");
        send_hand(ones, ones, 0, 0, 7'd64, 1, 1, '0, 1, "R8 64b narrow");
        send_hand(ones, ones, 1, 1, 7'd63, 1, 1, '0, 1, "R8 scalar low imm");
        // R9 scalar, shift 64, all ones + round gives 1
        send_hand(ones, {64'hAAAA_AAAA_AAAA_AAAA, 64'd5}, 1, 1, 7'd64, 1, 1,
                  {64'h0, 64'd6}, 0, "R9 scalar");
        // R1 width decode: 16-bit lanes with shift 16 vs 8-bit reading
        send_hand({8{16'h8000}}, '0, 1, 0, 7'd16, 1, 0, {8{16'h0001}}, 0, "R1 width16");

        // R1/R2 sweep: every width at shortest, middle and longest shift
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 3; k++) begin
                for (int p = 0; p < 3; p++) begin
                    for (int rn = 0; rn < 2; rn++) begin
                        int w;
                        logic [6:0] im;
                        logic [127:0] s;
                        w  = 8 << g;
                        im = (k == 0) ? 7'(w) : (k == 1) ? 7'(w + w/2) : 7'(2*w - 1);
                        s  = (p == 0) ? ones : (p == 1) ? alt :
                             {$urandom, $urandom, $urandom, $urandom};
                        send_model(s, {$urandom, $urandom, $urandom, $urandom},
                                   1, 0, im, rn[0], rn[0] ^ p[0], "R1 R2 sweep");
                        if (g < 3)
                            send_model(s, ones, 0, 0, im, rn[0], 1, "R7 sweep narrow");
                    end
                end
            end
        end

        // Random mix over all modes (R1..R9)
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ctl;
            ctl = $urandom;
            send_model({$urandom, $urandom, $urandom, $urandom},
                       {$urandom, $urandom, $urandom, $urandom},
                       ctl[0], (ctl[7:5] == 3'b000), ctl[14:8], ctl[1], ctl[2],
                       "R2 R8 R9 random");
            if (ctl[20:18] == 3'b000) idle();
        end

        idle();
        repeat (3) @(negedge clk);
        // R10 idle produces no strobe
        n_checks++;
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            n_fail++;
            $display("FAIL R10 idle: actual v=%b pending=%0d expected 0/0",
                     out_valid, sb.size());
        end
        finished = 1;
        finish_run();
    end

endmodule